// File: doc/BRIEF.md
# Multi-Channel DAC Control and Status Core

This block is the control and status logic of a multi-channel DAC. A host writes two registers through a write stream. The control word holds a power-down bit and a thermal-protection arm bit. A read-only flag in the same word reports a thermal trip. The GPIO word sets one general-purpose pin as a high-impedance input or as a driven output with a chosen level. The block sends the DAC output stages one `out_disable` level. When that level is high, every channel is held at its signal-ground level.

An over-temperature comparator feeds the block as a single digital input. Once the arm bit is set, an over-temperature sample latches a shutdown. The shutdown stays in force after the die cools. Only writing the arm bit back to 0 releases it, and that write also clears the trip flag. Power-down and thermal shutdown only gate the outputs. They never alter stored configuration, so the channels return to their previous levels when both are released.

Reads use a request stream and a one-entry response stream. The write stream never applies back-pressure: `wr_ready` is held high. A request is taken only while the response slot is empty or being drained in the same cycle. A response stays valid, with stable data, until `rsp_ready` accepts it.

Top module: `dac_ctl_core`

## Requirements
- R1: After the asynchronous active-low reset, `out_disable`, `thermal_shdn`, `gpio_oe`, `gpio_out` and `rsp_valid` are all 0, and a control readback returns 0.
- R2: A control write (`wr_sel`=0) with data bit 0 set drives `out_disable` high from the clock edge that accepts the write. A later control write with bit 0 clear drops it, provided no thermal shutdown is latched.
- R3: Setting or clearing power-down leaves the stored arm bit and the GPIO configuration unchanged. Readbacks and `gpio_oe`/`gpio_out` show the earlier values.
- R4: While the arm bit (control bit 1) is set, `over_temp` sampled high at a clock edge sets `thermal_shdn` and `out_disable` from that edge on. While the arm bit is clear, `over_temp` has no effect.
- R5: A latched thermal shutdown persists after `over_temp` falls. Control writes that keep bit 1 set do not release it, whatever they write to bit 0.
- R6: A control write with bit 1 clear releases the thermal shutdown and clears the trip flag at its accepting edge. That write takes priority over `over_temp` in the same cycle.
- R7: A control readback (`rq_sel`=0) returns power-down in bit 0, the arm bit in bit 1, the trip flag in bit 4, and 0 in every other bit.
- R8: A GPIO write (`wr_sel`=1) with data bit 1 set makes the pin an output (`gpio_oe`=1), driven at the level of data bit 0.
- R9: A GPIO write with data bit 1 clear makes the pin an input (`gpio_oe`=0) and forces `gpio_out` to 0.
- R10: A GPIO readback (`rq_sel`=1) returns in bit 0 the level of `gpio_in` after a two-flop synchronizer, with all other bits 0. A pin change is readable by a request accepted two edges after the change.
- R11: `wr_ready` is always 1. `rq_ready` equals `!rsp_valid || rsp_ready`. A response not accepted keeps `rsp_valid` high and `rsp_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accept, held at 1 |
| wr_sel | input | 1 | Target register: 0 control, 1 GPIO |
| wr_data | input | DATA_W | Write data |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request accept |
| rq_sel | input | 1 | Read target: 0 control, 1 GPIO |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accept |
| rsp_data | output | DATA_W | Read response word |
| over_temp | input | 1 | Die over-temperature comparator level |
| out_disable | output | 1 | Hold all channels at signal ground |
| thermal_shdn | output | 1 | Latched thermal shutdown state |
| gpio_oe | output | 1 | GPIO pin output enable |
| gpio_out | output | 1 | GPIO pin driven level |
| gpio_in | input | 1 | GPIO pin sampled level |

## Verification
Register writes, thermal trips and response captures all take effect at the single edge that accepts them. The bench therefore changes its inputs on the falling edge and checks the outputs on the next falling edge. A GPIO pin change takes two edges to pass the synchronizer, so the bench issues its readback request only after two falling edges have gone by. Read requests push their expected word into a queue at the moment they are issued. A monitor pops from that queue at each response handshake. This keeps the comparisons in order even while `rsp_ready` is held low to test back-pressure.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_GPIO = 1'b1
  } reg_sel_e;

  localparam int PD_BIT     = 0;
  localparam int ARM_BIT    = 1;
  localparam int TRIP_BIT   = 4;
  localparam int GP_LVL_BIT = 0;
  localparam int GP_DIR_BIT = 1;
  localparam int MIN_W      = TRIP_BIT + 1;
endpackage

// File: rtl/dac_ctl_regs.sv
module dac_ctl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic pd_in,
  input  logic arm_in,
  input  logic over_temp,
  output logic pd_q,
  output logic arm_q,
  output logic trip_q
);
  logic release_w;
  assign release_w = wr_en && !arm_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b0;
      arm_q <= 1'b0;
    end else if (wr_en) begin
      pd_q  <= pd_in;
      arm_q <= arm_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 trip_q <= 1'b0;
    else if (release_w)         trip_q <= 1'b0;
    else if (arm_q && over_temp) trip_q <= 1'b1;
  end

  assert_trip_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |-> arm_q);
  assert_trip_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && over_temp && !release_w) |=> trip_q);
  assert_trip_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !release_w) |=> trip_q);
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> !trip_q);
endmodule

// File: rtl/dac_gpio_port.sv
module dac_gpio_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic dir_in,
  input  logic lvl_in,
  input  logic pin_in,
  output logic oe_q,
  output logic lvl_q,
  output logic pin_sync
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else if (wr_en) begin
      oe_q  <= dir_in;
      lvl_q <= dir_in & lvl_in;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= pin_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_sync = sync_q[SYNC_STAGES-1];

  assert_input_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !lvl_q);
  assert_dir_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dir_in) |=> (oe_q && lvl_q == $past(lvl_in)));
endmodule

// File: rtl/dac_rd_port.sv
module dac_rd_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  assign rq_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rq_ready) begin
      rsp_valid <= rq_valid;
      if (rq_valid) rsp_data <= rd_word;
    end
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/dac_ctl_core.sv
module dac_ctl_core
  import dac_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic              rq_sel,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              over_temp,
  output logic              out_disable,
  output logic              thermal_shdn,
  output logic              gpio_oe,
  output logic              gpio_out,
  input  logic              gpio_in
);
  localparam int PAD_W = DATA_W - MIN_W;

  logic pd_q, arm_q, trip_q, pin_sync;
  logic wr_ctrl, wr_gpio;
  logic [DATA_W-1:0] ctrl_word, gpio_word, rd_word;

  assign wr_ready = 1'b1;
  assign wr_ctrl  = wr_valid && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign wr_gpio  = wr_valid && (reg_sel_e'(wr_sel) == SEL_GPIO);

  dac_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl),
    .pd_in(wr_data[PD_BIT]), .arm_in(wr_data[ARM_BIT]),
    .over_temp(over_temp),
    .pd_q(pd_q), .arm_q(arm_q), .trip_q(trip_q)
  );

  dac_gpio_port #(.SYNC_STAGES(SYNC_STAGES)) u_gpio (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_gpio),
    .dir_in(wr_data[GP_DIR_BIT]), .lvl_in(wr_data[GP_LVL_BIT]),
    .pin_in(gpio_in),
    .oe_q(gpio_oe), .lvl_q(gpio_out), .pin_sync(pin_sync)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctrl_word = {{PAD_W{1'b0}}, trip_q, 2'b00, arm_q, pd_q};
    end else begin : g_nopad
      assign ctrl_word = {trip_q, 2'b00, arm_q, pd_q};
    end
  endgenerate

  assign gpio_word = {{(DATA_W-1){1'b0}}, pin_sync};
  assign rd_word   = (reg_sel_e'(rq_sel) == SEL_GPIO) ? gpio_word : ctrl_word;

  dac_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rd_word(rd_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  assign thermal_shdn = trip_q;
  assign out_disable  = pd_q | trip_q;

  assert_pd_keeps_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(arm_q));
  assert_pd_keeps_gpio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gpio |=> ($stable(gpio_oe) && $stable(gpio_out)));
endmodule

// File: tb/dac_ctl_core_test.sv
module dac_ctl_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_sel = 0, rq_valid = 0, rq_sel = 0, rsp_ready = 1;
  logic over_temp = 0, gpio_in = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rq_ready, rsp_valid, out_disable, thermal_shdn, gpio_oe, gpio_out;
  logic [DW-1:0] rsp_data;

  int tests = 0, fails = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_ctl_core #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_sel(rq_sel), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .over_temp(over_temp), .out_disable(out_disable), .thermal_shdn(thermal_shdn),
    .gpio_oe(gpio_oe), .gpio_out(gpio_out), .gpio_in(gpio_in)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cword(input logic pd, input logic arm, input logic trip);
    return {3'b000, trip, 2'b00, arm, pd};
  endfunction

  task automatic wr(input logic sel, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(input logic sel, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rq_valid = 1; rq_sel = sel;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rq_valid = 0;
  endtask

  always @(posedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R11 unexpected response", rsp_data, '1);
      else check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_disable", {7'b0, out_disable}, 0);
    check("R1 thermal_shdn", {7'b0, thermal_shdn}, 0);
    check("R1 gpio_oe/out", {6'b0, gpio_oe, gpio_out}, 0);
    check("R1 rsp_valid", {7'b0, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R11 wr_ready", {7'b0, wr_ready}, 1);
    rd(0, cword(0, 0, 0), "R1 ctrl readback");

    // GPIO output then power-down keeps it
    wr(1, 8'h03);
    check("R8 oe high", {7'b0, gpio_oe}, 1);
    check("R8 level high", {7'b0, gpio_out}, 1);
    wr(1, 8'h02);
    check("R8 level low", {6'b0, gpio_oe, gpio_out}, 8'h02);
    wr(1, 8'h03);
    wr(0, 8'h01);
    check("R2 pd sets disable", {7'b0, out_disable}, 1);
    check("R3 gpio kept under pd", {6'b0, gpio_oe, gpio_out}, 8'h03);
    rd(0, cword(1, 0, 0), "R7 ctrl word pd");
    wr(0, 8'h00);
    check("R2 pd clear", {7'b0, out_disable}, 0);

    // over_temp ignored unarmed
    over_temp = 1;
    repeat (3) @(negedge clk);
    check("R4 unarmed ignore", {6'b0, thermal_shdn, out_disable}, 0);
    over_temp = 0;

    // arm, pd set, then pd clear keeps arm
    wr(0, 8'h03);
    wr(0, 8'h02);
    check("R3 arm kept after pd clear", {7'b0, out_disable}, 0);
    rd(0, cword(0, 1, 0), "R3 arm readback");

    // trip
    @(negedge clk); over_temp = 1;
    @(negedge clk);
    check("R4 trip shdn", {7'b0, thermal_shdn}, 1);
    check("R4 trip disable", {7'b0, out_disable}, 1);
    over_temp = 0;
    repeat (3) @(negedge clk);
    check("R5 persists after cool", {7'b0, thermal_shdn}, 1);
    wr(0, 8'h02);
    check("R5 rewrite arm keeps", {7'b0, out_disable}, 1);
    rd(0, cword(0, 1, 1), "R7 trip flag bit4");

    // release with over_temp still high: write wins
    over_temp = 1;
    wr(0, 8'h00);
    check("R6 release", {6'b0, thermal_shdn, out_disable}, 0);
    rd(0, cword(0, 0, 0), "R6 flag cleared");
    over_temp = 0;

    // GPIO input mode
    wr(1, 8'h01);
    check("R9 input mode", {6'b0, gpio_oe, gpio_out}, 0);
    @(negedge clk); gpio_in = 1;
    @(negedge clk); @(negedge clk);
    rd(1, 8'h01, "R10 pin high");
    gpio_in = 0;
    @(negedge clk); @(negedge clk);
    rd(1, 8'h00, "R10 pin low");

    // back-pressure
    @(negedge clk); rsp_ready = 0;
    rd(0, cword(0, 0, 0), "R11 held response");
    repeat (2) @(negedge clk);
    check("R11 valid held", {7'b0, rsp_valid}, 1);
    check("R11 rq_ready low", {7'b0, rq_ready}, 0);
    check("R11 data held", rsp_data, cword(0, 0, 0));
    rsp_ready = 1;
    repeat (3) @(negedge clk);
    check("R11 queue drained", 8'(exp_q.size()), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule